// File: doc/BRIEF.md
# Octet Ramp Pattern Checker

This block checks the octet ramp test pattern on one receive lane of a JESD204B link once the link is in its data phase. It sits after 8b/10b decoding and descrambling. It takes four lane octets per clock, with the earliest octet in the least significant byte, together with a valid flag and a marker that flags the word opening a multiframe. It predicts the value each octet should carry and compares all four octets in parallel. It counts wrong octets and records where the first wrong octet occurred.

The ramp value is the octet's position inside the multiframe, taken modulo 256. The multiframe length is F*K octets. F is the number of octets per frame. K is supplied as a minus-one field, so a field value of 3 means four frames per multiframe. A short multiframe repeats the run 0 to F*K-1. A multiframe longer than 256 octets wraps from 0xFF back to 0x00 inside itself. The checker keeps its own position counter and compares it with the incoming marker, so a marker that arrives at the wrong place is reported as a misalignment.

The multiframe length must be a multiple of four octets, so that every multiframe starts in byte 0 of a word. Checking starts at the first marker word that follows the enable input.

Top module: `ramp_octet_checker`

## Requirements
- R1: After reset the block is not armed, the mismatch count is zero, and the error flag, the alignment flag and the first-error valid flag are all low.
- R2: When F*K is below 256, the octet at position p of a multiframe is expected to equal p, so each multiframe carries 0 up to F*K-1. Position 0 is the least significant byte, bits [7:0], of the word that carries the marker. Octet n of a word, in bits [8n+7:8n], has the position of byte 0 plus n. A lane repeating 0..31 with F=8 and K=4 raises no error.
- R3: When F*K is above 256, the expected octet counts 0x00 to 0xFF, wraps to 0x00 and keeps counting until the multiframe ends.
- R4: When F*K is exactly 256, for example F=8 with a minus-one K field of 31, the expected octet runs 0x00 to 0xFF once per multiframe.
- R5: While the enable input is low, the block is disarmed and ignores all octets. Once the enable is high, checking starts with the first valid word that carries the marker, and that word is itself checked. Words before it change nothing.
- R6: Once armed, a valid word is misaligned in either of two cases: it carries the marker while the tracked position is not 0, or it lacks the marker while the tracked position is 0. A misaligned word sets a sticky alignment flag and the error flag. A marker always restarts the position count at 0 for its own word.
- R7: For each checked word, the mismatch count grows by the number of octets that differ from their expected value (0 to 4). The count saturates at 2^CNT_W-1.
- R8: The error flag is sticky. The first word holding a mismatched octet captures the position and the received value of its lowest mismatched octet. Later mismatches do not change this capture.
- R9: A synchronous clear zeroes the count, the error and alignment flags and the capture. It does not change the armed state or the position count.
- R10: A word with the valid flag low is ignored entirely, including a marker on it, and the position count does not advance.
- R11: The count, the flags and the capture reflect a word from the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_en | input | 1 | Enables checking; low disarms |
| clr | input | 1 | Synchronous clear of count, flags and capture |
| cfg_f | input | F_W (5) | Octets per frame, F |
| cfg_km1 | input | KM1_W (5) | Frames per multiframe minus one |
| oct_valid | input | 1 | The lane word is valid |
| oct_data | input | NOCT*8 (32) | Four lane octets, earliest in bits [7:0] |
| mf_start | input | 1 | This word opens a multiframe |
| armed | output | 1 | Checking is active |
| err_flag | output | 1 | Sticky: a mismatch or misalignment was seen |
| align_err | output | 1 | Sticky: a misaligned marker was seen |
| mism_cnt | output | CNT_W (16) | Saturating count of mismatched octets |
| first_vld | output | 1 | The first-error capture holds data |
| first_pos | output | MF_W (11) | Position of the first mismatched octet |
| first_oct | output | 8 | Received value of the first mismatched octet |

## Verification
The hardest state to reach is the saturated counter. It needs more than sixteen thousand words, every octet wrong. The bench streams bit-inverted ramp words through a 32-octet multiframe and samples the exact count just below the limit before it crosses. Misalignment is the other case that needs care. The bench places a marker part-way through a multiframe and drops a marker at a boundary. Each time it then confirms that a correct ramp which restarts at the new marker adds no mismatch. A sweep over several F and K pairs covers multiframes below, at and above 256 octets. On alternate pairs, idle cycles are inserted that carry garbage data and a false marker.

// File: rtl/rop_pkg.sv
// Package: shared types and constants for the octet ramp checker.
// Assumes one lane octet is eight bits wide.
package rop_pkg;
    localparam int OCT_W = 8;
    typedef logic [OCT_W-1:0] octet_t;
endpackage

// File: rtl/rop_pos_tracker.sv
// Module: rop_pos_tracker
// Tracks the octet position of byte 0 of each lane word inside the
// multiframe. It handles arming on the first marker after the enable and
// flags a misaligned marker.
// Assumes F*K is a multiple of NOCT, so every multiframe starts in byte 0.
module rop_pos_tracker #(
    parameter int NOCT  = 4,
    parameter int F_W   = 5,
    parameter int KM1_W = 5,
    parameter int MF_W  = F_W + KM1_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_en,
    input  logic [F_W-1:0]   cfg_f,
    input  logic [KM1_W-1:0] cfg_km1,
    input  logic             oct_valid,
    input  logic             mf_start,
    output logic             armed_q,
    output logic             word_live,
    output logic [MF_W-1:0]  base_pos,
    output logic             align_evt
);
    logic [MF_W-1:0] pos_q;
    logic [MF_W-1:0] mf_len;
    logic [MF_W:0]   pos_nxt;
    logic            arm_now;

    // Multiframe length in octets: F times (KM1 + 1).
    always_comb mf_len = MF_W'(cfg_f) * (MF_W'(cfg_km1) + MF_W'(1));

    // Arming state for this word: already armed, or armed by this marker.
    always_comb arm_now = chk_en && (armed_q || (oct_valid && mf_start));

    // A word is checked when it is valid and checking is active.
    always_comb word_live = oct_valid && arm_now;

    // A marker forces position 0; otherwise the tracked position is used.
    always_comb base_pos = mf_start ? '0 : pos_q;

    // Misalignment: the marker disagrees with a tracked position of 0.
    always_comb align_evt = oct_valid && chk_en && armed_q &&
                            (mf_start != (pos_q == '0));

    // Position after this word, wrapping at the multiframe end.
    always_comb begin
        pos_nxt = {1'b0, base_pos} + (MF_W+1)'(NOCT);
        if (pos_nxt >= {1'b0, mf_len}) pos_nxt = '0;
    end

    // Holds the armed state: cleared by the enable, set by a valid marker.
    always_ff @(posedge clk) begin
        if (!rst_n)                      armed_q <= 1'b0;
        else if (!chk_en)                armed_q <= 1'b0;
        else if (oct_valid && mf_start)  armed_q <= 1'b1;
    end

    // Advances the position counter on each checked word.
    always_ff @(posedge clk) begin
        if (!rst_n)          pos_q <= '0;
        else if (word_live)  pos_q <= pos_nxt[MF_W-1:0];
    end
endmodule

// File: rtl/rop_lane_cmp.sv
// Module: rop_lane_cmp
// Computes the expected ramp octet for each byte of a word in parallel
// and returns a mask of the bytes that differ.
// Assumes the expected value is the position modulo 256, with byte n
// at position base_pos + n.
module rop_lane_cmp
    import rop_pkg::*;
#(
    parameter int NOCT = 4,
    parameter int MF_W = 11
) (
    input  logic                  word_live,
    input  logic [MF_W-1:0]       base_pos,
    input  logic [NOCT*OCT_W-1:0] oct_data,
    output logic [NOCT-1:0]       miss_mask
);
    genvar gi;
    generate
        for (gi = 0; gi < NOCT; gi++) begin : g_lane
            octet_t exp_oct;
            octet_t rx_oct;
            // Expected value is the low byte of the octet's position.
            always_comb exp_oct = base_pos[OCT_W-1:0] + OCT_W'(gi);
            // Received byte of this lane.
            always_comb rx_oct = oct_data[gi*OCT_W +: OCT_W];
            // Flag a difference only on checked words.
            always_comb miss_mask[gi] = word_live && (rx_oct != exp_oct);
        end
    endgenerate
endmodule

// File: rtl/rop_err_log.sv
// Module: rop_err_log
// Accumulates the saturating mismatch count and the sticky flags, and
// captures the first mismatched octet.
// Assumes a clear takes priority over any event in the same cycle.
module rop_err_log
    import rop_pkg::*;
#(
    parameter int NOCT  = 4,
    parameter int MF_W  = 11,
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [NOCT-1:0]       miss_mask,
    input  logic                  align_evt,
    input  logic [MF_W-1:0]       base_pos,
    input  logic [NOCT*OCT_W-1:0] oct_data,
    output logic                  err_flag,
    output logic                  align_err,
    output logic [CNT_W-1:0]      mism_cnt,
    output logic                  first_vld,
    output logic [MF_W-1:0]       first_pos,
    output octet_t                first_oct
);
    localparam int PC_W = $clog2(NOCT + 1);

    logic [PC_W-1:0]  miss_num;
    logic [CNT_W:0]   cnt_sum;
    logic [CNT_W-1:0] cnt_nxt;
    logic [MF_W-1:0]  low_pos;
    octet_t           low_oct;

    // Counts the mismatched bytes in this word.
    always_comb begin
        miss_num = '0;
        for (int i = 0; i < NOCT; i++) miss_num += PC_W'(miss_mask[i]);
    end

    // Next count, clamped at the all-ones value.
    always_comb begin
        cnt_sum = {1'b0, mism_cnt} + (CNT_W+1)'(miss_num);
        cnt_nxt = cnt_sum[CNT_W] ? '1 : cnt_sum[CNT_W-1:0];
    end

    // Selects the lowest mismatched byte of this word.
    always_comb begin
        low_pos = base_pos;
        low_oct = oct_data[OCT_W-1:0];
        for (int i = NOCT - 1; i >= 0; i--) begin
            if (miss_mask[i]) begin
                low_pos = base_pos + MF_W'(i);
                low_oct = oct_data[i*OCT_W +: OCT_W];
            end
        end
    end

    // Updates the saturating mismatch count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) mism_cnt <= '0;
        else               mism_cnt <= cnt_nxt;
    end

    // Sets the sticky error and alignment flags.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err_flag  <= 1'b0;
            align_err <= 1'b0;
        end else begin
            if (|miss_mask || align_evt) err_flag  <= 1'b1;
            if (align_evt)               align_err <= 1'b1;
        end
    end

    // Captures the first mismatched octet and its position.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            first_vld <= 1'b0;
            first_pos <= '0;
            first_oct <= '0;
        end else if (!first_vld && |miss_mask) begin
            first_vld <= 1'b1;
            first_pos <= low_pos;
            first_oct <= low_oct;
        end
    end
endmodule

// File: rtl/ramp_octet_checker.sv
// Module: ramp_octet_checker (top)
// Checks the octet ramp test pattern on one receive lane, NOCT octets
// per clock. The expected value restarts at 0 on each multiframe and
// wraps at 256.
// Assumes F*K is a multiple of NOCT and the inputs are in the clk domain.
module ramp_octet_checker
    import rop_pkg::*;
#(
    parameter int NOCT  = 4,
    parameter int F_W   = 5,
    parameter int KM1_W = 5,
    parameter int CNT_W = 16,
    parameter int MF_W  = F_W + KM1_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  chk_en,
    input  logic                  clr,
    input  logic [F_W-1:0]        cfg_f,
    input  logic [KM1_W-1:0]      cfg_km1,
    input  logic                  oct_valid,
    input  logic [NOCT*OCT_W-1:0] oct_data,
    input  logic                  mf_start,
    output logic                  armed,
    output logic                  err_flag,
    output logic                  align_err,
    output logic [CNT_W-1:0]      mism_cnt,
    output logic                  first_vld,
    output logic [MF_W-1:0]       first_pos,
    output logic [OCT_W-1:0]      first_oct
);
    logic            word_live;
    logic            align_evt;
    logic [MF_W-1:0] base_pos;
    logic [NOCT-1:0] miss_mask;

    rop_pos_tracker #(.NOCT(NOCT), .F_W(F_W), .KM1_W(KM1_W), .MF_W(MF_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
        .cfg_f(cfg_f), .cfg_km1(cfg_km1),
        .oct_valid(oct_valid), .mf_start(mf_start),
        .armed_q(armed), .word_live(word_live),
        .base_pos(base_pos), .align_evt(align_evt)
    );

    rop_lane_cmp #(.NOCT(NOCT), .MF_W(MF_W)) u_cmp (
        .word_live(word_live), .base_pos(base_pos),
        .oct_data(oct_data), .miss_mask(miss_mask)
    );

    rop_err_log #(.NOCT(NOCT), .MF_W(MF_W), .CNT_W(CNT_W)) u_log (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .miss_mask(miss_mask), .align_evt(align_evt),
        .base_pos(base_pos), .oct_data(oct_data),
        .err_flag(err_flag), .align_err(align_err), .mism_cnt(mism_cnt),
        .first_vld(first_vld), .first_pos(first_pos), .first_oct(first_oct)
    );
endmodule

// File: rtl/rop_checker.sv
// Module: rop_checker
// Temporal properties of the checker's port behaviour, bound to the top.
module rop_checker #(
    parameter int CNT_W = 16,
    parameter int MF_W  = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chk_en,
    input logic             clr,
    input logic             oct_valid,
    input logic             mf_start,
    input logic             armed,
    input logic             err_flag,
    input logic             align_err,
    input logic [CNT_W-1:0] mism_cnt,
    input logic             first_vld,
    input logic [MF_W-1:0]  first_pos,
    input logic [7:0]       first_oct
);
    // R7: the count never falls except through a clear.
    p_cnt_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> mism_cnt >= $past(mism_cnt));

    // R8: the error flag stays set until cleared.
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> err_flag);

    // R8: a non-zero count always goes with the error flag.
    p_cnt_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mism_cnt != '0) |-> err_flag);

    // R8: once taken, the capture holds.
    p_first_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (first_vld && !clr) |=> ($stable(first_pos) && $stable(first_oct) && first_vld));

    // R9: a clear empties the count, the flags and the capture.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mism_cnt == '0 && !err_flag && !align_err && !first_vld));

    // R5: a low enable disarms on the next edge.
    p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> !armed);

    // R5: while disarmed and not arming, the count holds.
    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !(chk_en && oct_valid && mf_start) && !clr) |=> $stable(mism_cnt));

    // R10: an invalid word changes neither the count nor the arming.
    p_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!oct_valid && !clr && chk_en) |=> ($stable(mism_cnt) && $stable(armed)));

    // R6: the alignment flag is sticky and implies the error flag.
    p_align_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (align_err && !clr) |=> align_err);
    p_align_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> err_flag);
endmodule

bind ramp_octet_checker rop_checker #(.CNT_W(CNT_W), .MF_W(MF_W)) u_rop_chk (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .clr(clr),
    .oct_valid(oct_valid), .mf_start(mf_start), .armed(armed),
    .err_flag(err_flag), .align_err(align_err), .mism_cnt(mism_cnt),
    .first_vld(first_vld), .first_pos(first_pos), .first_oct(first_oct)
);

// File: tb/tb_ramp_octet_checker.sv
module tb_ramp_octet_checker;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_en = 1'b0;
    logic        clr = 1'b0;
    logic [4:0]  cfg_f = 5'd8;
    logic [4:0]  cfg_km1 = 5'd3;
    logic        oct_valid = 1'b0;
    logic [31:0] oct_data = '0;
    logic        mf_start = 1'b0;
    logic        armed, err_flag, align_err, first_vld;
    logic [15:0] mism_cnt;
    logic [10:0] first_pos;
    logic [7:0]  first_oct;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;

    ramp_octet_checker dut (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .clr(clr),
        .cfg_f(cfg_f), .cfg_km1(cfg_km1), .oct_valid(oct_valid),
        .oct_data(oct_data), .mf_start(mf_start), .armed(armed),
        .err_flag(err_flag), .align_err(align_err), .mism_cnt(mism_cnt),
        .first_vld(first_vld), .first_pos(first_pos), .first_oct(first_oct)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG_CYC && !done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WDOG_CYC);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ramp(input int p);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = 8'(p + i);
        return r;
    endfunction

    task automatic put(input logic [31:0] d, input logic mf);
        @(negedge clk);
        oct_valid = 1'b1; oct_data = d; mf_start = mf;
    endtask

    // Invalid cycle carrying garbage and a false marker (R10).
    task automatic idle();
        @(negedge clk);
        oct_valid = 1'b0; oct_data = 32'hDEAD_BEEF; mf_start = 1'b1;
    endtask

    task automatic do_clr();
        @(negedge clk);
        oct_valid = 1'b0; mf_start = 1'b0; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Sends nmf multiframes of ramp; in multiframe bad_mf, word bad_w gets
    // lanes in bad_lanes XORed with 8'h5A.
    task automatic send_ramp(input int len, input int nmf, input int bad_mf,
                             input int bad_w, input logic [3:0] bad_lanes, input bit gaps);
        for (int m = 0; m < nmf; m++) begin
            for (int w = 0; w < len / 4; w++) begin
                logic [31:0] d;
                d = ramp(w * 4);
                if (m == bad_mf && w == bad_w)
                    for (int i = 0; i < 4; i++)
                        if (bad_lanes[i]) d[i*8 +: 8] = d[i*8 +: 8] ^ 8'h5A;
                put(d, w == 0);
                if (gaps && (w % 3 == 1)) idle();
            end
        end
        idle();
    endtask

    initial begin
        int fv [8] = '{8, 8, 4, 1, 3, 5, 16, 12};
        int kv [8] = '{3, 31, 0, 3, 3, 19, 31, 31};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "armed", armed, 0);
        check("R1", "mism_cnt", mism_cnt, 0);
        check("R1", "err_flag", err_flag, 0);
        check("R1", "align_err", align_err, 0);
        check("R1", "first_vld", first_vld, 0);

        // R5: disabled, garbage with markers is ignored
        for (int w = 0; w < 16; w++) put(~ramp((w % 8) * 4), (w % 8) == 0);
        idle();
        check("R5", "armed while disabled", armed, 0);
        check("R5", "count while disabled", mism_cnt, 0);
        chk_en = 1'b1;
        for (int w = 1; w < 6; w++) put(~ramp(w * 4), 1'b0);
        idle();
        check("R5", "armed before marker", armed, 0);
        check("R5", "count before marker", mism_cnt, 0);
        send_ramp(32, 1, -1, 0, 4'b0, 0);
        check("R5", "armed after marker", armed, 1);
        check("R5", "count after arming", mism_cnt, 0);
        chk_en = 1'b0;
        idle();
        idle();
        check("R5", "disarm on enable low", armed, 0);

        // R2/R3/R4 sweep over F and K
        for (int c = 0; c < 8; c++) begin
            int len;
            string tag;
            len = fv[c] * (kv[c] + 1);
            tag = (len < 256) ? "R2" : ((len == 256) ? "R4" : "R3");
            chk_en = 1'b0;
            idle();
            cfg_f = 5'(fv[c]); cfg_km1 = 5'(kv[c]);
            chk_en = 1'b1;
            do_clr();
            send_ramp(len, 3, -1, 0, 4'b0, c[0]);
            check(tag, "clean ramp count", mism_cnt, 0);
            check(tag, "clean ramp err_flag", err_flag, 0);
            check("R10", "no align error with gaps", align_err, 0);
            send_ramp(len, 1, 0, len / 4 - 1, 4'b0100, c[0]);
            check(tag, "single bad octet count", mism_cnt, 1);
            check("R8", "first_pos", first_pos, len - 2);
            check("R8", "first_oct", first_oct, ((len - 2) & 255) ^ 8'h5A);
            check("R8", "first_vld", first_vld, 1);
            send_ramp(len, 1, 0, 0, 4'b1011, c[0]);
            check("R7", "three bad octets added", mism_cnt, 4);
            check("R8", "first_pos held", first_pos, len - 2);
            check("R8", "err_flag sticky", err_flag, 1);
            check("R6", "no align error", align_err, 0);
        end

        // R6: early marker, then resync to the new marker
        chk_en = 1'b0; idle();
        cfg_f = 5'd8; cfg_km1 = 5'd3; chk_en = 1'b1;
        do_clr();
        put(ramp(0), 1'b1);
        put(ramp(4), 1'b0);
        put(ramp(0), 1'b1);
        idle();
        check("R6", "early marker align_err", align_err, 1);
        check("R6", "early marker err_flag", err_flag, 1);
        check("R6", "resync word count", mism_cnt, 0);
        for (int w = 1; w < 8; w++) put(ramp(w * 4), 1'b0);
        send_ramp(32, 1, -1, 0, 4'b0, 0);
        check("R6", "count after resync", mism_cnt, 0);
        // R6: missing marker at the boundary
        do_clr();
        send_ramp(32, 1, -1, 0, 4'b0, 0);
        put(ramp(0), 1'b0);
        idle();
        check("R6", "missing marker align_err", align_err, 1);
        check("R6", "missing marker count", mism_cnt, 0);

        // R7: saturation with all octets wrong, R11 one-edge update
        do_clr();
        send_ramp(32, 1, -1, 0, 4'b0, 0);
        for (int w = 0; w < 16383; w++) put(~ramp((w % 8) * 4), (w % 8) == 0);
        @(negedge clk);
        oct_valid = 1'b0; mf_start = 1'b0;
        check("R11", "count after last word edge", mism_cnt, 65532);
        put(~ramp(24), 1'b0);
        put(~ramp(28), 1'b0);
        idle();
        check("R7", "saturated count", mism_cnt, 65535);
        send_ramp(32, 1, 0, 0, 4'b1111, 0);
        check("R7", "stays saturated", mism_cnt, 65535);

        // R9: clear keeps arming and position
        do_clr();
        check("R9", "count cleared", mism_cnt, 0);
        check("R9", "err_flag cleared", err_flag, 0);
        check("R9", "first_vld cleared", first_vld, 0);
        check("R9", "armed kept", armed, 1);
        send_ramp(32, 2, -1, 0, 4'b0, 1);
        check("R9", "clean after clear", mism_cnt, 0);
        check("R9", "no align after clear", align_err, 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule